// File: doc/BRIEF.md
# Receive Byte FIFO with Sync Gate and Status Flags

This block stores received bytes of a packet radio data path in a 32-entry circular buffer. Bytes arrive from an upstream deserializer as a valid/data pair. The block only accepts them once the sync-word detector has pulsed its indication, so bit noise that arrives before a packet starts never enters storage. A host drains the buffer through a pop interface. The read port always shows the oldest stored byte, without waiting a cycle.

The block drives a set of flags that are meant to feed interrupt lines: not-empty, fill-level threshold, full, a sticky overflow, and a one-cycle strobe for every committed byte. The threshold level is loaded through a small write port. A synchronous flush input empties the buffer and closes the sync gate, which readies the block for the next packet.

Top module: `rx_byte_fifo`

## Requirements
- R1: After reset the buffer is empty, every flag is low, the threshold register holds 16, and the sync gate is closed.
- R2: A byte offered while the sync gate is closed is discarded. This includes a byte offered in the same cycle as the sync pulse. The gate opens on the clock edge that samples `sync_ok_i` high.
- R3: With the gate open, every offered byte is stored while the buffer is not full. `rd_data_o` shows the oldest stored byte in the same cycle, and bytes leave in arrival order.
- R4: `wr_stb_o` is high for exactly the one cycle after each edge that commits a byte, and stays low otherwise.
- R5: `not_empty_o` is high exactly when at least one byte is stored.
- R6: `thresh_o` is high when the stored count is greater than or equal to the threshold register. A cycle with `thr_we_i` high loads `thr_i` into that register.
- R7: `full_o` is high exactly when 32 bytes are stored.
- R8: An offered byte with the gate open while full is dropped, and the stored data is left intact. It sets `ovf_o`, which stays high until a cycle with `ovf_clr_i` high and no new overflow. In a cycle with both a clear and an overflow, the set wins.
- R9: A push and a pop in the same cycle, with the buffer neither empty nor full, leave the count unchanged.
- R10: A pop while empty has no effect on the pointers or the flags.
- R11: `flush_i` empties the buffer and closes the sync gate on the next edge, overriding any push, pop or sync in that cycle. It leaves `ovf_o` and the threshold unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Synchronous empty and gate close |
| sync_ok_i | input | 1 | Sync-word detected pulse, opens the gate |
| wr_valid_i | input | 1 | Deserializer byte valid |
| wr_data_i | input | 8 | Deserializer byte |
| rd_pop_i | input | 1 | Host consumes the oldest byte |
| rd_data_o | output | 8 | Oldest stored byte |
| thr_we_i | input | 1 | Load the threshold register |
| thr_i | input | 6 | New threshold value |
| ovf_clr_i | input | 1 | Clear the sticky overflow flag |
| not_empty_o | output | 1 | At least one byte stored |
| thresh_o | output | 1 | Count at or above the threshold |
| full_o | output | 1 | All entries occupied |
| ovf_o | output | 1 | Sticky overflow |
| wr_stb_o | output | 1 | One-cycle pulse per committed byte |

## Verification
A wrong pointer shows up on `rd_data_o` at the first pop after the fault, as a byte out of order or a stale byte. This is why every drain compares each byte against a model queue. A wrong count shows first on the flags. `full_o` or `not_empty_o` changes one push too early or too late, and `thresh_o` flips at the wrong level. These flags are checked at every step around 0, the threshold, and 32. A gate or overflow state that is stuck or set falsely shows up within one cycle, as a stray `wr_stb_o` or a wrong `ovf_o` level.

// File: rtl/rx_fifo_pkg.sv
package rx_fifo_pkg;
    typedef logic [7:0] byte_t;

    typedef struct packed {
        logic not_empty;
        logic thresh;
        logic full;
        logic ovf;
        logic wstb;
    } fifo_flags_t;
endpackage

// File: rtl/rx_fifo_store.sv
module rx_fifo_store
    import rx_fifo_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [PTR_W-1:0] waddr,
    input  byte_t            wdata,
    input  logic [PTR_W-1:0] raddr,
    output byte_t            rdata
);
    byte_t mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/rx_fifo_ctrl.sv
module rx_fifo_ctrl
    import rx_fifo_pkg::*;
#(
    parameter int DEPTH   = 32,
    parameter int THR_RST = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             sync_ok,
    input  logic             wr_valid,
    input  logic             rd_pop,
    input  logic             thr_we,
    input  logic [CNT_W-1:0] thr,
    input  logic             ovf_clr,
    output logic             mem_we,
    output logic [PTR_W-1:0] wptr,
    output logic [PTR_W-1:0] rptr,
    output logic             gate_open,
    output fifo_flags_t      flags
);
    localparam logic [PTR_W-1:0] LAST  = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULLC = CNT_W'(DEPTH);

    typedef struct packed {
        logic [PTR_W-1:0] wp;
        logic [PTR_W-1:0] rp;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] thr;
        logic             gate;
        logic             ovf;
        logic             stb;
    } ctrl_t;

    ctrl_t st_d, st_q;
    logic  empty, full, push_ok, pop_ok, ovf_evt;

    always_comb begin
        empty   = (st_q.cnt == '0);
        full    = (st_q.cnt == FULLC);
        push_ok = wr_valid && st_q.gate && !full && !flush;
        pop_ok  = rd_pop && !empty && !flush;
        ovf_evt = wr_valid && st_q.gate && full && !flush;

        st_d     = st_q;
        st_d.stb = push_ok;
        st_d.ovf = ovf_evt || (st_q.ovf && !ovf_clr);
        if (thr_we) begin
            st_d.thr = thr;
        end
        if (flush) begin
            st_d.wp   = '0;
            st_d.rp   = '0;
            st_d.cnt  = '0;
            st_d.gate = 1'b0;
        end else begin
            st_d.gate = st_q.gate || sync_ok;
            if (push_ok) begin
                st_d.wp = (st_q.wp == LAST) ? '0 : st_q.wp + 1'b1;
            end
            if (pop_ok) begin
                st_d.rp = (st_q.rp == LAST) ? '0 : st_q.rp + 1'b1;
            end
            case ({push_ok, pop_ok})
                2'b10:   st_d.cnt = st_q.cnt + 1'b1;
                2'b01:   st_d.cnt = st_q.cnt - 1'b1;
                default: st_d.cnt = st_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.thr  <= CNT_W'(THR_RST);
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_we          = push_ok;
    assign wptr            = st_q.wp;
    assign rptr            = st_q.rp;
    assign gate_open       = st_q.gate;
    assign flags.not_empty = !empty;
    assign flags.thresh    = (st_q.cnt >= st_q.thr);
    assign flags.full      = full;
    assign flags.ovf       = st_q.ovf;
    assign flags.wstb      = st_q.stb;
endmodule

// File: rtl/rx_byte_fifo.sv
module rx_byte_fifo
    import rx_fifo_pkg::*;
#(
    parameter int DEPTH   = 32,
    parameter int THR_RST = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush_i,
    input  logic             sync_ok_i,
    input  logic             wr_valid_i,
    input  logic [7:0]       wr_data_i,
    input  logic             rd_pop_i,
    output logic [7:0]       rd_data_o,
    input  logic             thr_we_i,
    input  logic [CNT_W-1:0] thr_i,
    input  logic             ovf_clr_i,
    output logic             not_empty_o,
    output logic             thresh_o,
    output logic             full_o,
    output logic             ovf_o,
    output logic             wr_stb_o
);
    logic             mem_we;
    logic [PTR_W-1:0] wptr, rptr;
    logic             gate_open;
    fifo_flags_t      flags;

    rx_fifo_ctrl #(.DEPTH(DEPTH), .THR_RST(THR_RST)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush_i),
        .sync_ok  (sync_ok_i),
        .wr_valid (wr_valid_i),
        .rd_pop   (rd_pop_i),
        .thr_we   (thr_we_i),
        .thr      (thr_i),
        .ovf_clr  (ovf_clr_i),
        .mem_we   (mem_we),
        .wptr     (wptr),
        .rptr     (rptr),
        .gate_open(gate_open),
        .flags    (flags)
    );

    rx_fifo_store #(.DEPTH(DEPTH)) u_store (
        .clk  (clk),
        .we   (mem_we),
        .waddr(wptr),
        .wdata(wr_data_i),
        .raddr(rptr),
        .rdata(rd_data_o)
    );

    assign not_empty_o = flags.not_empty;
    assign thresh_o    = flags.thresh;
    assign full_o      = flags.full;
    assign ovf_o       = flags.ovf;
    assign wr_stb_o    = flags.wstb;
endmodule

// File: rtl/rx_byte_fifo_chk.sv
module rx_byte_fifo_chk (
    input logic clk,
    input logic rst_n,
    input logic flush_i,
    input logic sync_ok_i,
    input logic wr_valid_i,
    input logic rd_pop_i,
    input logic ovf_clr_i,
    input logic gate_open,
    input logic not_empty_o,
    input logic full_o,
    input logic ovf_o,
    input logic wr_stb_o
);
    AST_PRESYNC_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_open |=> !wr_stb_o); // R2
    AST_STB_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb_o |-> not_empty_o || $past(rd_pop_i) || $past(flush_i)); // R4
    AST_FULL_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        full_o |-> not_empty_o); // R7
    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        full_o && !rd_pop_i && !flush_i |=> full_o && !wr_stb_o); // R8
    AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
        full_o && gate_open && wr_valid_i && !flush_i |=> ovf_o); // R8
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o && !ovf_clr_i |=> ovf_o); // R8
    AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
        !not_empty_o && rd_pop_i && !(wr_valid_i && gate_open) |=> !not_empty_o); // R10
    AST_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> !not_empty_o && !gate_open && !wr_stb_o); // R11
endmodule

bind rx_byte_fifo rx_byte_fifo_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush_i    (flush_i),
    .sync_ok_i  (sync_ok_i),
    .wr_valid_i (wr_valid_i),
    .rd_pop_i   (rd_pop_i),
    .ovf_clr_i  (ovf_clr_i),
    .gate_open  (gate_open),
    .not_empty_o(not_empty_o),
    .full_o     (full_o),
    .ovf_o      (ovf_o),
    .wr_stb_o   (wr_stb_o)
);

// File: tb/sim_rx_byte_fifo.sv
module sim_rx_byte_fifo;
    localparam int CLK_P = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic flush_i = 0, sync_ok_i = 0, wr_valid_i = 0, rd_pop_i = 0;
    logic thr_we_i = 0, ovf_clr_i = 0;
    logic [7:0] wr_data_i = '0;
    logic [5:0] thr_i = '0;
    logic [7:0] rd_data_o;
    logic not_empty_o, thresh_o, full_o, ovf_o, wr_stb_o;

    int n_chk = 0, n_bad = 0;
    logic [7:0] mq[$];

    always #(CLK_P/2) clk = ~clk;

    rx_byte_fifo u0 (.*);

    initial begin
        #(CLK_P * 20000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run hung, actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
        wr_valid_i = 0; rd_pop_i = 0; sync_ok_i = 0; flush_i = 0;
        thr_we_i = 0; ovf_clr_i = 0;
    endtask

    task automatic push(logic [7:0] b);
        wr_valid_i = 1; wr_data_i = b;
        cyc();
        mq.push_back(b);
    endtask

    task automatic drain(string req);
        while (mq.size() > 0) begin
            logic [7:0] e;
            e = mq.pop_front();
            chk(req, {24'd0, rd_data_o}, {24'd0, e});
            rd_pop_i = 1;
            cyc();
        end
        chk("R5 drained", {31'd0, not_empty_o}, 0);
    endtask

    task automatic do_flush();
        flush_i = 1;
        cyc();
        mq.delete();
    endtask

    task automatic open_gate();
        sync_ok_i = 1;
        cyc();
    endtask

    task automatic t_reset();
        chk("R1 not_empty", {31'd0, not_empty_o}, 0);
        chk("R1 full", {31'd0, full_o}, 0);
        chk("R1 ovf", {31'd0, ovf_o}, 0);
        chk("R1 stb", {31'd0, wr_stb_o}, 0);
        chk("R1 thresh", {31'd0, thresh_o}, 0);
    endtask

    task automatic t_presync();
        for (int i = 0; i < 3; i++) begin
            wr_valid_i = 1; wr_data_i = 8'h55;
            cyc();
            chk("R2 no strobe", {31'd0, wr_stb_o}, 0);
        end
        wr_valid_i = 1; sync_ok_i = 1; wr_data_i = 8'hAA;
        cyc();
        chk("R2 sync-cycle byte dropped", {31'd0, not_empty_o}, 0);
    endtask

    task automatic t_order();
        for (int i = 0; i < 5; i++) begin
            push(8'h10 + 8'(i));
            chk("R4 strobe", {31'd0, wr_stb_o}, 1);
            chk("R5 not_empty", {31'd0, not_empty_o}, 1);
        end
        cyc();
        chk("R4 strobe idle", {31'd0, wr_stb_o}, 0);
        drain("R3 order");
        rd_pop_i = 1;
        cyc();
        chk("R10 pop empty", {31'd0, not_empty_o}, 0);
        push(8'h77);
        drain("R10 pointers intact");
    endtask

    task automatic t_thresh();
        thr_we_i = 1; thr_i = 6'd4;
        cyc();
        for (int i = 0; i < 3; i++) push(8'h20 + 8'(i));
        chk("R6 below", {31'd0, thresh_o}, 0);
        push(8'h23);
        chk("R6 at", {31'd0, thresh_o}, 1);
        rd_pop_i = 1;
        cyc();
        void'(mq.pop_front());
        chk("R6 drop below", {31'd0, thresh_o}, 0);
        drain("R6 data");
    endtask

    task automatic t_full();
        thr_we_i = 1; thr_i = 6'd16;
        cyc();
        for (int i = 0; i < 32; i++) begin
            push(8'(i * 7 + 3));
            if (i == 15) chk("R6 default 16", {31'd0, thresh_o}, 1);
            if (i == 30) chk("R7 not yet full", {31'd0, full_o}, 0);
        end
        chk("R7 full", {31'd0, full_o}, 1);
        wr_valid_i = 1; wr_data_i = 8'hEE;
        cyc();
        chk("R8 ovf set", {31'd0, ovf_o}, 1);
        chk("R8 no strobe", {31'd0, wr_stb_o}, 0);
        wr_valid_i = 1; wr_data_i = 8'hEF; ovf_clr_i = 1;
        cyc();
        chk("R8 set beats clear", {31'd0, ovf_o}, 1);
        ovf_clr_i = 1;
        cyc();
        chk("R8 cleared", {31'd0, ovf_o}, 0);
        drain("R8 data intact");
    endtask

    task automatic t_simul();
        thr_we_i = 1; thr_i = 6'd2;
        cyc();
        push(8'hA1);
        push(8'hA2);
        wr_valid_i = 1; wr_data_i = 8'hA3; rd_pop_i = 1;
        cyc();
        void'(mq.pop_front());
        mq.push_back(8'hA3);
        chk("R9 count kept", {31'd0, thresh_o}, 1);
        rd_pop_i = 1;
        cyc();
        void'(mq.pop_front());
        chk("R9 one pop leaves one", {31'd0, thresh_o}, 0);
        drain("R9 data");
    endtask

    task automatic t_flush();
        for (int i = 0; i < 32; i++) push(8'(i));
        wr_valid_i = 1;
        cyc();
        chk("R8 ovf before flush", {31'd0, ovf_o}, 1);
        flush_i = 1; wr_valid_i = 1; sync_ok_i = 1;
        cyc();
        mq.delete();
        chk("R11 empty", {31'd0, not_empty_o}, 0);
        chk("R11 ovf kept", {31'd0, ovf_o}, 1);
        chk("R11 thr kept", {31'd0, thresh_o}, 0);
        wr_valid_i = 1; wr_data_i = 8'h99;
        cyc();
        chk("R11 gate closed", {31'd0, not_empty_o}, 0);
        ovf_clr_i = 1;
        cyc();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_presync();
        t_order();
        t_thresh();
        t_full();
        t_simul();
        t_flush();
        open_gate();
        push(8'h42);
        drain("R3 after flush");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule